// File: doc/BRIEF.md
# ADC Conversion Sequencer with Hardware Averaging

This block sequences one analog-to-digital conversion channel on converter-clock ticks. A write on the channel-control port carries a 5-bit channel number and an interrupt-enable bit, and it starts a conversion on that channel. Each conversion has a fixed lead-in of 6 ticks, then one or more sample windows. Each window is a base time of 25 ticks plus a configurable long-sample extension. The sample value is taken from a data input port at the last tick of each window. When averaging is on, the samples are summed, divided by their count with a right shift, and the result is masked to the selected resolution.

A conversion-complete flag rises when a result is delivered. An interrupt follows the flag if the starting write enabled it. Reading the result clears both. A continuous mode restarts the same channel as soon as a conversion ends. A protection setting decides whether a new result may replace one that has not been read yet. Writing the all-ones channel number stops any activity and starts nothing.

Top module: `adc_conv_seq`

## Requirements
- R1: A conversion takes exactly 6 + N×(25 + L) ticks, counted over the cycles where `conv_tick` is high, starting after the cycle in which `ctl_we` is taken. `coco` rises at the edge of the final tick.
- R2: With `long_smp`=0, `smp_time` 00/01/10/11 gives L = 3/5/7/9. With `long_smp`=1, it gives L = 13/17/21/25.
- R3: With `avg_en`=0, N = 1 whatever `avg_cnt` holds. With `avg_en`=1, `avg_cnt` 00/01/10/11 gives N = 4/8/16/32.
- R4: The result is the sum of the N samples shifted right by log2(N), truncated.
- R5: The result is masked by `res_mode`: 00 keeps 8 bits, 01 keeps 10 bits, 10 (and 11) keep 12 bits.
- R6: A write with channel 0x1F stops any conversion in progress (`busy` low on the next cycle) and starts nothing, so `coco` stays low.
- R7: `coco` is set when a conversion completes. A `res_rd` pulse clears it.
- R8: `irq` is high exactly while `coco` is high and the interrupt-enable bit of the last channel-control write was 1.
- R9: With `cont_en`=1, the next conversion on the same channel starts at the completion edge, so the next completion follows 6 + N×(25 + L) ticks later.
- R10: With `ovw_en`=0, a result that completes while `coco` is still set is discarded and `result` keeps the old value. With `ovw_en`=1, the new result replaces it.
- R11: `sample_req` is high in exactly N cycles per conversion, one per sample; `sample_in` is captured at the clock edge closing each such cycle; `cur_chan` shows the channel of the last write.
- R12: After reset, `busy`, `coco`, `irq` and `sample_req` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_tick | input | 1 | Converter-clock enable; one tick per high cycle |
| ctl_we | input | 1 | Channel-control write strobe |
| ctl_chan | input | 5 | Channel number; 0x1F means stop |
| ctl_ien | input | 1 | Interrupt enable for this conversion |
| long_smp | input | 1 | Selects the long sample-time range |
| smp_time | input | 2 | Sample-time step within the range |
| avg_en | input | 1 | Hardware averaging enable |
| avg_cnt | input | 2 | Averaging count select |
| res_mode | input | 2 | Result resolution select |
| cont_en | input | 1 | Continuous conversion enable |
| ovw_en | input | 1 | Allow a new result to replace an unread one |
| sample_in | input | 12 | Converter sample data |
| res_rd | input | 1 | Result read strobe; clears the flag |
| sample_req | output | 1 | High in the cycle whose closing edge captures `sample_in` |
| busy | output | 1 | A conversion is in progress |
| cur_chan | output | 5 | Channel of the last control write |
| result | output | 12 | Latest accepted result |
| coco | output | 1 | Conversion-complete flag |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The hardest case to reach is a result that completes while the previous one is still unread with overwrite disabled. It only happens when conversions run back to back and nobody reads. The bench reaches it by starting continuous mode and not pulsing the read strobe. It then changes the sample data, so a wrongly accepted result would show a different value. After several discarded conversions it enables overwrite and expects the new value. Sample values also change from one sample to the next, so the averaging shift and truncation can be checked from the data. Every sample-time and averaging code is covered by the vectors.

// File: rtl/adc_seq_pkg.sv
// Shared types and decode helpers for the conversion sequencer.
// Assumes a 12-bit sample path; resolution codes pick 8, 10 or 12 bits.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LEAD   = 2'd1,
        SEQ_SAMPLE = 2'd2
    } seq_state_e;

    localparam int LEAD_TICKS = 6;
    localparam int BASE_TICKS = 25;

    // Long-sample extension in ticks from the range bit and step field
    function automatic logic [5:0] lsa_ticks(input logic long_mode, input logic [1:0] step);
        logic [5:0] t;
        case ({long_mode, step})
            3'b000:  t = 6'd3;
            3'b001:  t = 6'd5;
            3'b010:  t = 6'd7;
            3'b011:  t = 6'd9;
            3'b100:  t = 6'd13;
            3'b101:  t = 6'd17;
            3'b110:  t = 6'd21;
            default: t = 6'd25;
        endcase
        return t;
    endfunction

    // Number of result bits kept for a resolution code
    function automatic int res_bits(input logic [1:0] mode);
        case (mode)
            2'b00:   return 8;
            2'b01:   return 10;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_timing.sv
// Decodes the live sample-time and averaging settings into a sample
// window length (base + extension) and log2 of the sample count.
// Purely combinational; the controller latches the outputs at start.
module adc_seq_timing
    import adc_seq_pkg::*;
#(
    parameter int PER_W = 6
) (
    input  logic             long_smp,
    input  logic [1:0]       smp_time,
    input  logic             avg_en,
    input  logic [1:0]       avg_cnt,
    output logic [PER_W-1:0] period,
    output logic [2:0]       log2n
);

    // Window length: fixed base plus the selected extension
    always_comb begin
        period = PER_W'(BASE_TICKS) + PER_W'(lsa_ticks(long_smp, smp_time));
    end

    // Sample count exponent: 0 without averaging, 2..5 with it
    always_comb begin
        log2n = avg_en ? (3'd2 + {1'b0, avg_cnt}) : 3'd0;
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Conversion state machine: lead-in ticks, then N sample windows.
// Assumes conv_tick is a one-cycle enable; config is latched at each start.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int PER_W = 6,
    parameter int NS_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_we,
    input  logic [CH_W-1:0]  cmd_chan,
    input  logic             cmd_ien,
    input  logic             cont_en,
    input  logic [PER_W-1:0] period,
    input  logic [2:0]       log2n,
    output logic             busy,
    output logic [CH_W-1:0]  chan,
    output logic             ien,
    output logic             capture,
    output logic             first_smp,
    output logic             done,
    output logic [2:0]       cur_log2n
);

    localparam logic [CH_W-1:0]  STOP_CH   = '1;
    localparam logic [PER_W-1:0] LEAD_LAST = PER_W'(LEAD_TICKS - 1);

    seq_state_e       state_q;
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] per_q;
    logic [2:0]       l2n_q;
    logic [NS_W-1:0]  idx_q;
    logic             last_smp;

    // Sample-position decode
    assign last_smp  = (idx_q == NS_W'((1 << l2n_q) - 1));
    assign first_smp = (idx_q == '0);
    assign capture   = (state_q == SEQ_SAMPLE) && tick && (cnt_q == '0) && !cmd_we;
    assign done      = capture && last_smp;
    assign busy      = (state_q != SEQ_IDLE);
    assign cur_log2n = l2n_q;

    // Sequencing of lead-in and sample windows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            per_q   <= '0;
            l2n_q   <= '0;
            idx_q   <= '0;
            chan    <= '0;
            ien     <= 1'b0;
        end else if (cmd_we) begin
            chan <= cmd_chan;
            ien  <= cmd_ien;
            if (cmd_chan == STOP_CH) begin
                state_q <= SEQ_IDLE;
            end else begin
                state_q <= SEQ_LEAD;
                cnt_q   <= LEAD_LAST;
                per_q   <= period;
                l2n_q   <= log2n;
                idx_q   <= '0;
            end
        end else if (tick) begin
            case (state_q)
                SEQ_LEAD: begin
                    if (cnt_q == '0) begin
                        state_q <= SEQ_SAMPLE;
                        cnt_q   <= per_q - 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SEQ_SAMPLE: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (!last_smp) begin
                        idx_q <= idx_q + 1'b1;
                        cnt_q <= per_q - 1'b1;
                    end else if (cont_en) begin
                        state_q <= SEQ_LEAD;
                        cnt_q   <= LEAD_LAST;
                        per_q   <= period;
                        l2n_q   <= log2n;
                        idx_q   <= '0;
                    end else begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R6: a stop write leaves the sequencer idle
    p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && (cmd_chan == STOP_CH) |=> !busy);

    // R1: without a tick or a write the countdown holds
    p_tick_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !cmd_we |=> $stable(cnt_q) && $stable(state_q));

    // R9: continuous mode keeps the sequencer running past completion
    p_cont_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && cont_en |=> busy && $stable(chan));

endmodule

// File: rtl/adc_seq_accum.sv
// Accumulates samples of one conversion, then forms the truncated average
// and masks it to the selected resolution. Assumes DATA_W is 12.
module adc_seq_accum
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int MAX_L2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              first_smp,
    input  logic              done,
    input  logic [DATA_W-1:0] sample,
    input  logic [2:0]        log2n,
    input  logic [1:0]        res_mode,
    output logic [DATA_W-1:0] res_val
);

    localparam int ACC_W = DATA_W + MAX_L2;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  sum_now;
    logic [ACC_W-1:0]  avg_full;
    logic [DATA_W-1:0] mask;

    // Running sum including the sample taken this cycle
    always_comb begin
        sum_now  = (first_smp ? '0 : acc_q) + ACC_W'(sample);
        avg_full = sum_now >> log2n;
        mask     = {DATA_W{1'b1}} >> (DATA_W - res_bits(res_mode));
        res_val  = avg_full[DATA_W-1:0] & mask;
    end

    // Store the running sum at each captured sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (capture) begin
            acc_q <= sum_now;
        end
    end

    // R4: the shifted average of N samples fits the sample width
    p_avg_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (avg_full >> DATA_W) == '0);

endmodule

// File: rtl/adc_seq_result.sv
// Result register and complete flag with overwrite protection.
// Assumes done is a single-cycle pulse from the controller.
module adc_seq_result #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] res_val,
    input  logic              rd_en,
    input  logic              ovw_en,
    output logic [DATA_W-1:0] result,
    output logic              coco
);

    logic accept;

    // A new result is taken unless an unread one is protected
    assign accept = !coco || ovw_en || rd_en;

    // Result and flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            coco   <= 1'b0;
        end else begin
            if (done && accept) begin
                result <= res_val;
            end
            if (done) begin
                coco <= 1'b1;
            end else if (rd_en) begin
                coco <= 1'b0;
            end
        end
    end

    // R7: completion sets the flag
    p_coco_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> coco);

    // R7: a read without completion clears the flag
    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !done |=> !coco);

    // R10: a protected unread result is kept
    p_keep_unread_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && coco && !ovw_en && !rd_en |=> $stable(result));

endmodule

// File: rtl/adc_conv_seq.sv
// Top of the conversion sequencer: ties decode, control, accumulation
// and result/flag logic together and forms the interrupt.
// Assumes one conversion channel and a 12-bit sample input.
module adc_conv_seq #(
    parameter int DATA_W = 12,
    parameter int CH_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_tick,
    input  logic              ctl_we,
    input  logic [CH_W-1:0]   ctl_chan,
    input  logic              ctl_ien,
    input  logic              long_smp,
    input  logic [1:0]        smp_time,
    input  logic              avg_en,
    input  logic [1:0]        avg_cnt,
    input  logic [1:0]        res_mode,
    input  logic              cont_en,
    input  logic              ovw_en,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              res_rd,
    output logic              sample_req,
    output logic              busy,
    output logic [CH_W-1:0]   cur_chan,
    output logic [DATA_W-1:0] result,
    output logic              coco,
    output logic              irq
);

    localparam int PER_W  = 6;
    localparam int MAX_L2 = 5;
    localparam int NS_W   = MAX_L2 + 1;

    logic [PER_W-1:0]  period;
    logic [2:0]        log2n;
    logic [2:0]        cur_log2n;
    logic              ien;
    logic              capture;
    logic              first_smp;
    logic              done;
    logic [DATA_W-1:0] res_val;

    adc_seq_timing #(.PER_W(PER_W)) timing_i (
        .long_smp (long_smp),
        .smp_time (smp_time),
        .avg_en   (avg_en),
        .avg_cnt  (avg_cnt),
        .period   (period),
        .log2n    (log2n)
    );

    adc_seq_ctrl #(.CH_W(CH_W), .PER_W(PER_W), .NS_W(NS_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (conv_tick),
        .cmd_we    (ctl_we),
        .cmd_chan  (ctl_chan),
        .cmd_ien   (ctl_ien),
        .cont_en   (cont_en),
        .period    (period),
        .log2n     (log2n),
        .busy      (busy),
        .chan      (cur_chan),
        .ien       (ien),
        .capture   (capture),
        .first_smp (first_smp),
        .done      (done),
        .cur_log2n (cur_log2n)
    );

    adc_seq_accum #(.DATA_W(DATA_W), .MAX_L2(MAX_L2)) accum_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .first_smp (first_smp),
        .done      (done),
        .sample    (sample_in),
        .log2n     (cur_log2n),
        .res_mode  (res_mode),
        .res_val   (res_val)
    );

    adc_seq_result #(.DATA_W(DATA_W)) result_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .res_val (res_val),
        .rd_en   (res_rd),
        .ovw_en  (ovw_en),
        .result  (result),
        .coco    (coco)
    );

    // Interrupt follows the flag when the starting write enabled it
    assign irq        = coco && ien;
    assign sample_req = capture;

    // R8: an enabled completion raises the interrupt
    p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && ien && !ctl_we |=> irq);

    // R11: no sample is requested while idle in the previous cycle
    p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |-> $past(busy));

endmodule

// File: tb/adc_conv_seq_tb_top.sv
`timescale 1ns/1ps
module adc_conv_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        conv_tick;
    logic        ctl_we;
    logic [4:0]  ctl_chan;
    logic        ctl_ien;
    logic        long_smp;
    logic [1:0]  smp_time;
    logic        avg_en;
    logic [1:0]  avg_cnt;
    logic [1:0]  res_mode;
    logic        cont_en;
    logic        ovw_en;
    logic [11:0] sample_in;
    logic        res_rd;
    logic        sample_req;
    logic        busy;
    logic [4:0]  cur_chan;
    logic [11:0] result;
    logic        coco;
    logic        irq;

    always #2 clk = ~clk;

    adc_conv_seq dut_i (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .ctl_we(ctl_we),
        .ctl_chan(ctl_chan), .ctl_ien(ctl_ien), .long_smp(long_smp),
        .smp_time(smp_time), .avg_en(avg_en), .avg_cnt(avg_cnt),
        .res_mode(res_mode), .cont_en(cont_en), .ovw_en(ovw_en),
        .sample_in(sample_in), .res_rd(res_rd), .sample_req(sample_req),
        .busy(busy), .cur_chan(cur_chan), .result(result), .coco(coco), .irq(irq)
    );

    typedef struct packed {
        logic        lsmp;
        logic [1:0]  stime;
        logic        aen;
        logic [1:0]  acnt;
        logic [1:0]  mode;
        logic [11:0] base;
        logic [3:0]  step;
        logic [15:0] ticks;
        logic [11:0] res;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 1'b0, 2'd0, 2'd2, 12'hABC, 4'd0,  16'd34,   12'hABC},
        '{1'b0, 2'd3, 1'b1, 2'd0, 2'd2, 12'd100, 4'd1,  16'd142,  12'd101},
        '{1'b1, 2'd0, 1'b1, 2'd1, 2'd1, 12'hFF0, 4'd1,  16'd310,  12'h3F3},
        '{1'b1, 2'd3, 1'b1, 2'd3, 2'd0, 12'd0,   4'd3,  16'd1606, 12'h02E},
        '{1'b1, 2'd2, 1'b1, 2'd2, 2'd2, 12'd2000,4'd10, 16'd742,  12'd2075},
        '{1'b0, 2'd1, 1'b0, 2'd0, 2'd0, 12'h3A5, 4'd0,  16'd36,   12'h0A5},
        '{1'b1, 2'd1, 1'b0, 2'd3, 2'd2, 12'h123, 4'd5,  16'd48,   12'h123},
        '{1'b0, 2'd2, 1'b1, 2'd0, 2'd2, 12'hFFF, 4'd0,  16'd134,  12'hFFF}
    };

    int   checks = 0;
    int   errors = 0;
    int   k      = 0;
    logic [11:0] base_v = '0;
    logic [3:0]  step_v = '0;
    logic        alt_tick = 1'b0;
    logic        edge_tick = 1'b0;
    int   n_ticks;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: pass the edge, then drive tick and sample data at the falling edge
    task automatic cyc();
        edge_tick = conv_tick;
        @(posedge clk);
        @(negedge clk);
        conv_tick = alt_tick ? ~conv_tick : 1'b1;
        sample_in = base_v + 12'(k * int'(step_v));
        #1;
        if (sample_req) k = k + 1;
    endtask

    task automatic start(input logic [4:0] ch, input logic ie);
        ctl_chan = ch;
        ctl_ien  = ie;
        ctl_we   = 1'b1;
        k        = 0;
        sample_in = base_v;
        cyc();
        ctl_we   = 1'b0;
    endtask

    task automatic wait_done();
        int cycles;
        cycles  = 0;
        n_ticks = 0;
        while (!coco && cycles < 8000) begin
            cyc();
            if (edge_tick) n_ticks++;
            cycles++;
        end
    endtask

    task automatic read_res();
        res_rd = 1'b1;
        cyc();
        res_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; conv_tick = 1'b1; ctl_we = 1'b0; ctl_chan = '0; ctl_ien = 1'b0;
        long_smp = 1'b0; smp_time = '0; avg_en = 1'b0; avg_cnt = '0; res_mode = 2'd2;
        cont_en = 1'b0; ovw_en = 1'b1; sample_in = '0; res_rd = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R12: reset state
        chk("R12 busy",   busy, 0);
        chk("R12 coco",   coco, 0);
        chk("R12 irq",    irq, 0);
        chk("R12 req",    sample_req, 0);
        chk("R12 result", result, 0);

        // Vector table: timing, averaging, masking, flag and interrupt
        for (int i = 0; i < NVEC; i++) begin
            long_smp = VECS[i].lsmp; smp_time = VECS[i].stime;
            avg_en = VECS[i].aen; avg_cnt = VECS[i].acnt; res_mode = VECS[i].mode;
            base_v = VECS[i].base; step_v = VECS[i].step;
            start(5'(i + 3), 1'b1);
            chk("R11 channel", cur_chan, i + 3);
            wait_done();
            chk("R1 R2 R3 conversion ticks", n_ticks, int'(VECS[i].ticks));
            chk("R4 R5 result", result, int'(VECS[i].res));
            chk("R11 samples taken", k, VECS[i].aen ? (4 << VECS[i].acnt) : 1);
            chk("R8 irq raised", irq, 1);
            read_res();
            chk("R7 flag cleared", coco, 0);
            chk("R8 irq cleared", irq, 0);
        end

        // R8: interrupt disabled write
        long_smp = 1'b0; smp_time = '0; avg_en = 1'b0; res_mode = 2'd2;
        base_v = 12'h5A5; step_v = '0;
        start(5'd1, 1'b0);
        wait_done();
        chk("R7 flag set", coco, 1);
        chk("R8 irq masked", irq, 0);
        read_res();

        // R1: tick gating with every other cycle ticking
        alt_tick = 1'b1;
        start(5'd2, 1'b1);
        wait_done();
        chk("R1 gated ticks", n_ticks, 34);
        alt_tick = 1'b0;
        read_res();

        // R6: stop mid-conversion and from idle
        long_smp = 1'b1; smp_time = 2'd3; avg_en = 1'b1; avg_cnt = 2'd3;
        start(5'd4, 1'b1);
        repeat (10) cyc();
        chk("R6 busy before stop", busy, 1);
        start(5'h1F, 1'b1);
        chk("R6 busy after stop", busy, 0);
        repeat (300) cyc();
        chk("R6 no completion", coco, 0);
        start(5'h1F, 1'b0);
        chk("R6 idle stop", busy, 0);

        // R9: continuous restart period
        long_smp = 1'b0; smp_time = '0; avg_en = 1'b0;
        cont_en = 1'b1; base_v = 12'h0F0;
        start(5'd6, 1'b1);
        wait_done();
        chk("R9 first result", result, 12'h0F0);
        base_v = 12'h0E1;
        read_res();
        n_ticks = 1;
        while (!coco && n_ticks < 200) begin
            cyc();
            if (edge_tick) n_ticks++;
        end
        chk("R9 restart ticks", n_ticks, 34);
        chk("R9 second result", result, 12'h0E1);
        chk("R9 channel kept", cur_chan, 6);

        // R10: overwrite protection with unread results
        ovw_en = 1'b0;
        read_res();
        while (!coco) cyc();
        chk("R10 base result", result, 12'h0E1);
        base_v = 12'h222;
        repeat (80) cyc();
        chk("R10 kept unread", result, 12'h0E1);
        chk("R10 flag held", coco, 1);
        ovw_en = 1'b1;
        repeat (40) cyc();
        chk("R10 overwritten", result, 12'h222);
        cont_en = 1'b0;
        start(5'h1F, 1'b0);
        chk("R6 stop continuous", busy, 0);
        read_res();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule